// File: doc/BRIEF.md
# FIFO Read-Side Retransmit Controller

This block owns the read pointer and the output data register of a synchronous FIFO. Besides ordinary reads, it accepts an active-low retransmit request on the read clock. The request rewinds the read pointer to array location zero, so the words stored since reset can be read again, as many times as needed.

A latency option is captured while master reset is held. In normal latency the rewind only moves the pointer, and the first word comes back on a later read. In zero latency the word at location zero is loaded into the output register on the same edge that takes the request, and the pointer moves on to location one.

The memory array and the write side sit outside the block. The memory is read combinationally through the address this block drives. The block takes the write pointer and reports the occupancy that the flag logic uses.

Top module: `rtx_read_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising edge, the read pointer and `dout` clear to zero. After reset, `mem_addr` is 0 and `occupancy` equals `wr_ptr`.
- R2: A rising edge with `rd_en` high, `rtx_n` high and nonzero occupancy loads `dout` with the word at `mem_addr` and advances `mem_addr` by one.
- R3: A read attempt with zero occupancy is ignored. `dout` and `mem_addr` keep their values.
- R4: In normal latency, `rtx_n` low at a rising edge sets the read pointer to 0 and leaves `dout` unchanged.
- R5: In zero latency, `rtx_n` low at a rising edge with `wr_ptr` nonzero loads `dout` with the word at location 0 on that same edge. During that cycle `mem_addr` reads 0, and afterwards the pointer is 1.
- R6: In normal latency, the word at location 0 reaches `dout` on the first read-enabled edge after the retransmit.
- R7: When `rtx_n` is low and `rd_en` is high on the same edge, only the retransmit takes effect.
- R8: The latency option is sampled from `rtx_mode_n` while `rst_n` is low: 0 selects zero latency, 1 selects normal latency. Changes on `rtx_mode_n` after reset have no effect.
- R9: `occupancy` equals `wr_ptr` minus the read pointer, modulo 2^(ADDR_W+1). It is recomputed from the rewound pointer after every retransmit.
- R10: Retransmit may be repeated any number of times. Each request rewinds again.
- R11: A zero-latency retransmit while `wr_ptr` is 0 rewinds the pointer to 0 and leaves `dout` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read clock |
| rst_n | input | 1 | Synchronous master reset, active low |
| rtx_mode_n | input | 1 | Latency option, sampled during reset (0 = zero latency) |
| rd_en | input | 1 | Read enable |
| rtx_n | input | 1 | Retransmit request, active low |
| wr_ptr | input | ADDR_W+1 | Write pointer from the write side, with wrap bit |
| mem_rdata | input | DATA_W | Combinational read data of the array at `mem_addr` |
| mem_addr | output | ADDR_W | Array read address |
| dout | output | DATA_W | Output data register |
| occupancy | output | ADDR_W+1 | Words between the read and write pointers |

## Verification
The hardest case to reach is a zero-latency retransmit that lands on a nonempty FIFO after the mode pin has been flipped. Reaching it takes a reset with the pin low, writes, partial reads, and then the pin driven high before the request. The bench builds this sequence on purpose. It also drives a zero-latency request before any write, and a request together with a read. Seeded random cycles then mix reads, writes and rewinds in both modes. In those cycles, rewinds fall at many fill levels and pointer positions.

// File: rtl/rtx_pkg.sv
package rtx_pkg;

   typedef enum logic {
      RTX_NORMAL = 1'b0,
      RTX_ZERO   = 1'b1
   } rtx_lat_e;

   typedef enum logic [1:0] {
      OP_IDLE     = 2'd0,
      OP_READ     = 2'd1,
      OP_RTX_NORM = 2'd2,
      OP_RTX_ZERO = 2'd3
   } rd_op_e;

endpackage

// File: rtl/rtx_mode_latch.sv
module rtx_mode_latch
   import rtx_pkg::*;
#(
   parameter bit ZL_ENABLE = 1'b1
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     mode_n,
   output rtx_lat_e lat
);

   generate
      if (ZL_ENABLE) begin : g_latch
         rtx_lat_e lat_q;

         always_ff @(posedge clk) begin
            if (!rst_n) lat_q <= mode_n ? RTX_NORMAL : RTX_ZERO;
         end

         assign lat = lat_q;

         // R8
         mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> $stable(lat_q));
      end else begin : g_fixed
         assign lat = RTX_NORMAL;
      end
   endgenerate

endmodule

// File: rtl/rtx_op_decode.sv
module rtx_op_decode
   import rtx_pkg::*;
(
   input  logic     rtx_n,
   input  logic     rd_en,
   input  rtx_lat_e lat,
   input  logic     occ_zero,
   input  logic     stored_zero,
   output rd_op_e   op
);

   always_comb begin
      op = OP_IDLE;
      if (!rtx_n) begin
         if (lat == RTX_ZERO && !stored_zero) op = OP_RTX_ZERO;
         else                                 op = OP_RTX_NORM;
      end else if (rd_en && !occ_zero) begin
         op = OP_READ;
      end
   end

endmodule

// File: rtl/rtx_rd_pointer.sv
module rtx_rd_pointer
   import rtx_pkg::*;
#(
   parameter int PTR_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  rd_op_e           op,
   input  logic [PTR_W-1:0] wr_ptr,
   output logic [PTR_W-1:0] ptr,
   output logic [PTR_W-1:0] occ,
   output logic             occ_zero,
   output logic             stored_zero
);

   logic [PTR_W-1:0] ptr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else begin
         unique case (op)
            OP_READ:     ptr_q <= ptr_q + PTR_W'(1);
            OP_RTX_NORM: ptr_q <= '0;
            OP_RTX_ZERO: ptr_q <= PTR_W'(1);
            default:     ptr_q <= ptr_q;
         endcase
      end
   end

   assign ptr         = ptr_q;
   assign occ         = wr_ptr - ptr_q;
   assign occ_zero    = (occ == '0);
   assign stored_zero = (wr_ptr == '0);

   // R1
   ptr_reset_chk: assert property (@(posedge clk)
      !rst_n |=> ptr_q == '0);

   // R4
   rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op == OP_RTX_NORM |=> ptr_q == '0);

   // R3
   empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op == OP_IDLE |=> $stable(ptr_q));

endmodule

// File: rtl/rtx_out_reg.sv
module rtx_out_reg
   import rtx_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  rd_op_e            op,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [DATA_W-1:0] dout
);

   logic [DATA_W-1:0] dout_q;
   logic              load;

   assign load = (op == OP_READ) || (op == OP_RTX_ZERO);

   always_ff @(posedge clk) begin
      if (!rst_n)    dout_q <= '0;
      else if (load) dout_q <= mem_rdata;
   end

   assign dout = dout_q;

   // R1
   dout_reset_chk: assert property (@(posedge clk)
      !rst_n |=> dout_q == '0);

   // R4
   norm_rtx_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op == OP_RTX_NORM |=> $stable(dout_q));

endmodule

// File: rtl/rtx_read_ctrl.sv
module rtx_read_ctrl
   import rtx_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int DEPTH     = 16,
   parameter bit ZL_ENABLE = 1'b1,
   localparam int ADDR_W   = $clog2(DEPTH),
   localparam int PTR_W    = ADDR_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rtx_mode_n,
   input  logic              rd_en,
   input  logic              rtx_n,
   input  logic [PTR_W-1:0]  wr_ptr,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] dout,
   output logic [PTR_W-1:0]  occupancy
);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("rtx_read_ctrl: DEPTH must be a power of two >= 2");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("rtx_read_ctrl: DATA_W must be positive");
      end
   endgenerate

   rtx_lat_e         lat;
   rd_op_e           op;
   logic [PTR_W-1:0] ptr;
   logic             occ_zero;
   logic             stored_zero;

   rtx_mode_latch #(.ZL_ENABLE(ZL_ENABLE)) u_mode (
      .clk    (clk),
      .rst_n  (rst_n),
      .mode_n (rtx_mode_n),
      .lat    (lat)
   );

   rtx_op_decode u_dec (
      .rtx_n       (rtx_n),
      .rd_en       (rd_en),
      .lat         (lat),
      .occ_zero    (occ_zero),
      .stored_zero (stored_zero),
      .op          (op)
   );

   rtx_rd_pointer #(.PTR_W(PTR_W)) u_ptr (
      .clk         (clk),
      .rst_n       (rst_n),
      .op          (op),
      .wr_ptr      (wr_ptr),
      .ptr         (ptr),
      .occ         (occupancy),
      .occ_zero    (occ_zero),
      .stored_zero (stored_zero)
   );

   rtx_out_reg #(.DATA_W(DATA_W)) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .op        (op),
      .mem_rdata (mem_rdata),
      .dout      (dout)
   );

   // A zero-latency rewind reads location zero on the requesting edge
   assign mem_addr = (op == OP_RTX_ZERO) ? '0 : ptr[ADDR_W-1:0];

   // R2
   read_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rtx_n && rd_en && occupancy != '0) |=> ptr == $past(ptr) + PTR_W'(1));

   // R5
   zl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rtx_n && lat == RTX_ZERO && wr_ptr != '0)
         |=> (dout == $past(mem_rdata)) && (ptr == PTR_W'(1)));

   // R7
   rtx_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rtx_n && rd_en && lat == RTX_NORMAL) |=> ptr == '0);

   // R3
   empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rtx_n && occupancy == '0) |=> $stable(dout));

endmodule

// File: tb/rtx_read_ctrl_tb.sv
module rtx_read_ctrl_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int DATA_W     = 16;
   localparam int DEPTH      = 16;
   localparam int ADDR_W     = $clog2(DEPTH);
   localparam int PTR_W      = ADDR_W + 1;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              rtx_mode_n = 1'b1;
   logic              rd_en = 1'b0;
   logic              rtx_n = 1'b1;
   logic [PTR_W-1:0]  wr_ptr = '0;
   logic [DATA_W-1:0] mem_rdata;
   logic [ADDR_W-1:0] mem_addr;
   logic [DATA_W-1:0] dout;
   logic [PTR_W-1:0]  occupancy;

   logic [DATA_W-1:0] mem [DEPTH];

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   // reference model state
   logic [PTR_W-1:0]  m_ptr;
   logic [DATA_W-1:0] m_dout;
   bit                m_zl;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign mem_rdata = mem[mem_addr];

   rtx_read_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ZL_ENABLE(1'b1)) dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .rtx_mode_n (rtx_mode_n),
      .rd_en      (rd_en),
      .rtx_n      (rtx_n),
      .wr_ptr     (wr_ptr),
      .mem_rdata  (mem_rdata),
      .mem_addr   (mem_addr),
      .dout       (dout),
      .occupancy  (occupancy)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [PTR_W-1:0] exp_occ(input logic [PTR_W-1:0] w,
                                                input logic [PTR_W-1:0] r);
      return w - r;
   endfunction

   task automatic do_reset(input bit mode_n);
      rst_n      = 1'b0;
      rtx_mode_n = mode_n;
      rd_en      = 1'b0;
      rtx_n      = 1'b1;
      wr_ptr     = '0;
      m_ptr      = '0;
      m_dout     = '0;
      m_zl       = !mode_n;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n      = 1'b1;
      rtx_mode_n = !mode_n;   // later pin changes must be ignored (R8)
      #1;
      chk("R1 dout", dout, 0);
      chk("R1 addr", mem_addr, 0);
      chk("R1 occ", occupancy, 0);
   endtask

   // one clock cycle: drive, predict, apply write side, check
   task automatic step(input bit rd, input bit rtx, input bit wr);
      string             tag;
      logic [DATA_W-1:0] wdata;
      logic [PTR_W-1:0]  occ_now;
      rd_en   = rd;
      rtx_n   = !rtx;
      occ_now = exp_occ(wr_ptr, m_ptr);
      if (rtx) begin
         if (m_zl && wr_ptr != '0) begin
            m_dout = mem[0];
            m_ptr  = PTR_W'(1);
            tag    = rd ? "R7 zl" : "R5";
         end else begin
            m_ptr = '0;
            tag   = rd ? "R7" : (m_zl ? "R11" : "R4");
         end
      end else if (rd && occ_now != '0) begin
         m_dout = mem[m_ptr[ADDR_W-1:0]];
         m_ptr  = m_ptr + PTR_W'(1);
         tag    = "R2";
      end else begin
         tag = rd ? "R3" : "R9 idle";
      end
      wdata = DATA_W'($urandom);
      @(posedge clk);
      #1;
      if (wr && wr_ptr < PTR_W'(DEPTH)) begin
         mem[wr_ptr[ADDR_W-1:0]] = wdata;
         wr_ptr = wr_ptr + PTR_W'(1);
      end
      @(negedge clk);
      rd_en = 1'b0;
      rtx_n = 1'b1;
      #1;
      chk({tag, " dout"}, dout, m_dout);
      chk({tag, " addr"}, mem_addr, m_ptr[ADDR_W-1:0]);
      chk("R9 occ", occupancy, exp_occ(wr_ptr, m_ptr));
   endtask

   task automatic random_phase(input int n);
      for (int i = 0; i < n; i++) begin
         step(1'($urandom % 2), ($urandom % 8) == 0, ($urandom % 3) == 0);
      end
   endtask

   initial begin
      void'($urandom(32'h5eed_0042));
      for (int i = 0; i < DEPTH; i++) mem[i] = '0;

      // ---- normal latency ----
      do_reset(1'b1);
      step(1, 0, 0);                       // R3 read on empty
      for (int i = 0; i < 5; i++) step(0, 0, 1);
      chk("R9 after writes", occupancy, 5);
      for (int i = 0; i < 3; i++) step(1, 0, 0);   // R2
      step(0, 1, 0);                       // R4 rewind keeps dout
      chk("R9 rewound", occupancy, 5);
      step(1, 0, 0);
      chk("R6 first word", dout, mem[0]);
      step(1, 0, 0);
      step(1, 1, 0);                       // R7 rewind wins
      chk("R7 addr", mem_addr, 0);
      step(0, 1, 0);                       // R10 repeated
      step(0, 1, 0);
      step(1, 0, 0);
      chk("R10 reread", dout, mem[0]);
      random_phase(300);

      // ---- zero latency ----
      do_reset(1'b0);
      step(0, 1, 0);                       // R11 nothing stored yet
      chk("R11 dout", dout, 0);
      for (int i = 0; i < 4; i++) step(0, 0, 1);
      step(1, 0, 0);
      step(1, 0, 0);
      step(0, 1, 0);                       // R5 with mode pin now high
      chk("R8 still zero latency", dout, mem[0]);
      chk("R5 addr", mem_addr, 1);
      step(1, 0, 0);
      chk("R5 next word", dout, mem[1]);
      step(1, 1, 0);                       // R7 in zero latency
      step(0, 1, 0);                       // R10
      chk("R10 zl", dout, mem[0]);
      random_phase(300);

      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule